// File: doc/BRIEF.md
# Endian-configurable host register port

This block is the slave side of a CPU register interface. A host reaches a small bank of 1-, 2- and 4-byte registers through an 8-bit register address. It frames each access with an active-low select and an active-low read or write strobe. A 4-bit device address qualifies every access. The block answers only when that address equals its own 4-bit identity, so up to sixteen devices can share one select line. An acknowledge output stays low while the block inserts wait states. It rises once data is ready and drops after the host releases the access.

The host data bus is 32 bits wide. A strap pin, captured while reset is held, fixes the byte order. The port width is 8, 16 or 32 bits and is held in a configuration register. It comes out of reset at 8 bits. A port narrower than a register reaches that register one byte or one half at a time, and the low address bits select the part. The block also holds a 32-bit interrupt mask against a 32-bit status word and drives an active-low interrupt request.

Register map (decoded from address bits 7:2):
- 0x00: port-width register, 1 byte. Bits 1:0 give the width code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 8-bit. Bits 7:2 read as zero.
- 0x04: status, 4 bytes, read-only. It is a registered copy of `status_in`.
- 0x08: interrupt mask, 4 bytes, read/write.
- 0x0C: scratch, 2 bytes, read/write.

Top module: `host_reg_port`

## Requirements
- R1: With the strap at 0 (little endian), register byte k of the accessed part travels on data bits 8k+7:8k, so byte 0 is on bits 7:0.
- R2: With the strap at 1 (big endian), register byte k travels on bits 31-8k:24-8k, so byte 0 is on bits 31:24. This holds at every port width; an 8-bit port uses bits 31:24 and a 16-bit port uses bits 31:16.
- R3: The strap is sampled only while reset is asserted. Changing it after reset release has no effect on lane mapping.
- R4: After reset the port is 8 bits wide. Each access carries the single register byte whose index is given by address bits 1:0, and a write changes only that byte.
- R5: Writing code 1 or 2 into bits 1:0 at address 0x00 makes following accesses 16 or 32 bits wide. A 16-bit access carries the half selected by address bit 1; a 32-bit access carries the whole register.
- R6: When the port is wider than the register part being accessed, port bytes beyond the register read as zero. For example, an 8-bit register read on a 16- or 32-bit port has zero on bits 31:8 when little endian.
- R7: An access is taken only while select is low, a strobe is low and the device address equals the device identity. Otherwise the acknowledge and its enable stay low and no register changes.
- R8: The acknowledge rises on the third rising clock edge at which a qualified access is sampled, which is two cycles after the first sampling edge. It falls at the first edge after the access is released. Read data is valid and its enable is high while the acknowledge is high.
- R9: The interrupt output is low exactly when some bit is set in both the registered status word and the mask. The status copy is refreshed every clock.
- R10: The mask resets to all zeros, so the interrupt output is high after reset whatever the status.
- R11: Addresses at 0x10 and above read as zero, and writes to them or to the status register change nothing.
- R12: An access released before its acknowledge rises writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_n | input | 1 | Active-low select |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_addr | input | 8 | Register address |
| chip_addr | input | 4 | Device address presented by the host |
| chip_id | input | 4 | This device's identity |
| big_endian_strap | input | 1 | Byte-order strap, 1 = big endian |
| host_wdata | input | 32 | Write data bus |
| host_rdata | output | 32 | Read data bus |
| host_rdata_en | output | 1 | Read data drive enable |
| host_ack | output | 1 | Acknowledge, high when the access completes |
| host_ack_en | output | 1 | Acknowledge drive enable, high while qualified |
| status_in | input | 32 | Status bits for the status register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume the following about the host:
- Select, strobes, address and write data are synchronous to the clock and stay stable from the first sampling edge until the acknowledge is seen.
- Read and write strobes are never low together.
- In the 16- and 32-bit modes, addresses are aligned to the port width.
- The host releases an access before it starts the next one.

The stimulus keeps within these rules. It drives every input on the falling clock edge and holds each access until the acknowledge appears. It steps the sweep addresses by the current port width. Only the deliberate abort and mismatch cases depart from the normal handshake.

// File: rtl/hrp_pkg.sv
// Package: shared types and register region codes for the host register port.
// Assumes the register address is split into a region index (upper bits)
// and a byte offset (low bits) of lane-count width.
package hrp_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_WAIT1 = 2'd1,
        HS_WAIT2 = 2'd2,
        HS_DONE  = 2'd3
    } hs_state_t;

    localparam int RGN_WIDTH_CFG = 0;
    localparam int RGN_STATUS    = 1;
    localparam int RGN_MASK      = 2;
    localparam int RGN_SCRATCH   = 3;

endpackage

// File: rtl/hrp_handshake.sv
// Module: access handshake FSM. A qualified access is sampled, two wait
// states follow, then the acknowledge is held high until the access is
// released. Assumes qual is synchronous to clk.
module hrp_handshake
    import hrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic ack,
    output logic commit
);

    hs_state_t st_q, st_d;

    // Next state: any release returns to idle; otherwise step toward done.
    always_comb begin
        st_d = st_q;
        if (!qual) begin
            st_d = HS_IDLE;
        end else begin
            case (st_q)
                HS_IDLE:  st_d = HS_WAIT1;
                HS_WAIT1: st_d = HS_WAIT2;
                HS_WAIT2: st_d = HS_DONE;
                default:  st_d = HS_DONE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    assign ack    = (st_q == HS_DONE);
    assign commit = (st_q == HS_WAIT2) && qual;

    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> ($past(qual, 1) && $past(qual, 2) && $past(qual, 3))); // R8
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !qual) |=> !ack); // R8
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R12

endmodule

// File: rtl/hrp_lane_steer.sv
// Module: byte-lane steering. Maps register bytes onto bus lanes for reads
// and bus lanes onto register byte enables for writes, from the port width
// in bytes, the byte offset of the accessed part and the byte order.
// Assumes wbytes is 1, 2 or LANES and off is aligned to wbytes.
module hrp_lane_steer #(
    parameter  int LANES = 4,
    localparam int OW    = $clog2(LANES),
    localparam int IW    = OW + 1
) (
    input  logic                 big,
    input  logic [IW-1:0]        wbytes,
    input  logic [OW-1:0]        off,
    input  logic [IW-1:0]        reg_size,
    input  logic [8*LANES-1:0]   reg_val,
    input  logic [8*LANES-1:0]   bus_wdata,
    output logic [8*LANES-1:0]   rd_bus,
    output logic [LANES-1:0]     be,
    output logic [8*LANES-1:0]   wr_bytes
);

    // Read side: each lane picks the register byte its port byte points at.
    for (genvar L = 0; L < LANES; L++) begin : g_rd
        logic [IW-1:0] pb;
        logic [IW-1:0] rb;
        assign pb = big ? IW'(LANES - 1 - L) : IW'(L);
        assign rb = IW'(off) + pb;
        assign rd_bus[8*L +: 8] = ((pb < wbytes) && (rb < reg_size))
                                  ? reg_val[8*rb[OW-1:0] +: 8] : 8'h00;
    end

    // Write side: each register byte finds its source lane and enable.
    for (genvar K = 0; K < LANES; K++) begin : g_wr
        logic [IW-1:0] jj;
        logic [OW-1:0] ln;
        assign jj = IW'(K) - IW'(off);
        assign ln = big ? (OW'(LANES - 1) - jj[OW-1:0]) : jj[OW-1:0];
        assign be[K] = (IW'(K) >= IW'(off)) && (jj < wbytes) && (IW'(K) < reg_size);
        assign wr_bytes[8*K +: 8] = bus_wdata[8*ln +: 8];
    end

    // Guard: a write never touches more bytes than the port carries.
    always_comb begin
        if (!$isunknown(be) && !$isunknown(wbytes)) begin
            AST_BE_WITHIN_PORT: assert ($countones(be) <= int'(wbytes)); // R4
        end
    end

endmodule

// File: rtl/hrp_regs.sv
// Module: register bank holding the port-width code, a registered status
// copy, the interrupt mask and a scratch register, plus the interrupt
// request. Assumes be/wr_bytes are already in register byte order.
module hrp_regs
    import hrp_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int RGN_W     = 6,
    parameter  int SCR_BYTES = 2,
    localparam int LANES     = DATA_W / 8,
    localparam int IW        = $clog2(LANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RGN_W-1:0]  rgn,
    input  logic              wr_en,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wr_bytes,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] reg_val,
    output logic [IW-1:0]     reg_size,
    output logic [1:0]        width_code,
    output logic              irq_n
);

    logic [1:0]             cfg_q;
    logic [DATA_W-1:0]      stat_q;
    logic [DATA_W-1:0]      mask_q;
    logic [8*SCR_BYTES-1:0] scr_q;

    logic hit_cfg, hit_mask, hit_scr;
    assign hit_cfg  = wr_en && (rgn == RGN_W'(RGN_WIDTH_CFG));
    assign hit_mask = wr_en && (rgn == RGN_W'(RGN_MASK));
    assign hit_scr  = wr_en && (rgn == RGN_W'(RGN_SCRATCH));

    // Port-width code: only bits 1:0 of byte 0 are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_q <= 2'd0;
        else if (hit_cfg && be[0])  cfg_q <= wr_bytes[1:0];
    end

    // Status copy refreshed every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= status_in;
    end

    // Mask bytes, each written only when its byte enable is set.
    for (genvar L = 0; L < LANES; L++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)                 mask_q[8*L +: 8] <= 8'h00;
            else if (hit_mask && be[L]) mask_q[8*L +: 8] <= wr_bytes[8*L +: 8];
        end
    end

    // Scratch bytes.
    for (genvar L = 0; L < SCR_BYTES; L++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n)                scr_q[8*L +: 8] <= 8'h00;
            else if (hit_scr && be[L]) scr_q[8*L +: 8] <= wr_bytes[8*L +: 8];
        end
    end

    // Read mux: value and byte size of the addressed register.
    always_comb begin
        reg_val  = '0;
        reg_size = '0;
        case (rgn)
            RGN_W'(RGN_WIDTH_CFG): begin reg_val = DATA_W'(cfg_q); reg_size = IW'(1);         end
            RGN_W'(RGN_STATUS):    begin reg_val = stat_q;         reg_size = IW'(LANES);     end
            RGN_W'(RGN_MASK):      begin reg_val = mask_q;         reg_size = IW'(LANES);     end
            RGN_W'(RGN_SCRATCH):   begin reg_val = DATA_W'(scr_q); reg_size = IW'(SCR_BYTES); end
            default: ;
        endcase
    end

    assign width_code = cfg_q;
    assign irq_n      = ~|(stat_q & mask_q);

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q)); // R7
    AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q)); // R5

endmodule

// File: rtl/host_reg_port.sv
// Module: top of the host register port. Qualifies accesses, runs the
// handshake, steers lanes per width and byte order, and commits reads and
// writes on the last wait state. Assumes host inputs are synchronous to clk
// and held until the acknowledge is seen.
module host_reg_port #(
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 8,
    parameter  int ID_W   = 4,
    localparam int LANES  = DATA_W / 8,
    localparam int OW     = $clog2(LANES),
    localparam int IW     = OW + 1,
    localparam int RGN_W  = ADDR_W - OW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ID_W-1:0]   chip_addr,
    input  logic [ID_W-1:0]   chip_id,
    input  logic              big_endian_strap,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdata_en,
    output logic              host_ack,
    output logic              host_ack_en,
    input  logic [DATA_W-1:0] status_in,
    output logic              irq_n
);

    logic              big_q;
    logic              qual, commit;
    logic [1:0]        width_code;
    logic [IW-1:0]     wbytes;
    logic [OW-1:0]     byte_off;
    logic [IW-1:0]     reg_size;
    logic [DATA_W-1:0] reg_val, rd_bus, wr_bytes, rdata_q;
    logic [LANES-1:0]  be;

    // Byte-order strap captured only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) big_q <= big_endian_strap;
    end

    assign qual = !host_sel_n && (!host_rd_n || !host_wr_n) && (chip_addr == chip_id);

    // Port width in bytes from the width code.
    always_comb begin
        case (width_code)
            2'd1:    wbytes = IW'(2);
            2'd2:    wbytes = IW'(LANES);
            default: wbytes = IW'(1);
        endcase
    end

    assign byte_off = host_addr[OW-1:0] & ~OW'(wbytes - IW'(1));

    hrp_handshake u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual   (qual),
        .ack    (host_ack),
        .commit (commit)
    );

    hrp_lane_steer #(.LANES(LANES)) u_lanes (
        .big       (big_q),
        .wbytes    (wbytes),
        .off       (byte_off),
        .reg_size  (reg_size),
        .reg_val   (reg_val),
        .bus_wdata (host_wdata),
        .rd_bus    (rd_bus),
        .be        (be),
        .wr_bytes  (wr_bytes)
    );

    hrp_regs #(.DATA_W(DATA_W), .RGN_W(RGN_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rgn        (host_addr[ADDR_W-1:OW]),
        .wr_en      (commit && !host_wr_n),
        .be         (be),
        .wr_bytes   (wr_bytes),
        .status_in  (status_in),
        .reg_val    (reg_val),
        .reg_size   (reg_size),
        .width_code (width_code),
        .irq_n      (irq_n)
    );

    // Read data captured on the final wait state.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata_q <= '0;
        else if (commit && !host_rd_n) rdata_q <= rd_bus;
    end

    assign host_rdata    = rdata_q;
    assign host_rdata_en = host_ack && qual && !host_rd_n;
    assign host_ack_en   = qual;

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(big_q)); // R3
    AST_NO_ACK_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && !host_ack) |=> !host_ack); // R7

endmodule

// File: tb/sim_host_reg_port.sv
// Bench: sweeps both byte orders and all three port widths over the whole
// register map, plus qualification, abort and interrupt cases, against an
// arithmetic model of the register bank.
module sim_host_reg_port;

    logic        clk = 1'b0;
    logic        rst_n, host_sel_n, host_rd_n, host_wr_n;
    logic [7:0]  host_addr;
    logic [3:0]  chip_addr, chip_id;
    logic        big_endian_strap;
    logic [31:0] host_wdata, host_rdata, status_in;
    logic        host_rdata_en, host_ack, host_ack_en, irq_n;

    always #5 clk = ~clk;

    host_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_addr(host_addr), .chip_addr(chip_addr),
        .chip_id(chip_id), .big_endian_strap(big_endian_strap),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdata_en(host_rdata_en), .host_ack(host_ack),
        .host_ack_en(host_ack_en), .status_in(status_in), .irq_n(irq_n)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model state
    bit          m_big;
    logic [1:0]  m_code;
    logic [31:0] m_stat, m_mask;
    logic [15:0] m_scr;

    function automatic int port_w();
        case (m_code)
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic void reg_info(input logic [7:0] a, output logic [31:0] v, output int sz);
        case (int'(a) / 4)
            0:       begin v = {30'd0, m_code}; sz = 1; end
            1:       begin v = m_stat;          sz = 4; end
            2:       begin v = m_mask;          sz = 4; end
            3:       begin v = {16'd0, m_scr};  sz = 2; end
            default: begin v = 32'd0;           sz = 0; end
        endcase
    endfunction

    function automatic int part_off(input logic [7:0] a);
        int w = port_w();
        return (int'(a) % 4) - ((int'(a) % 4) % w);
    endfunction

    function automatic int part_len(input int off, input int sz);
        int w = port_w();
        if (off >= sz) return 0;
        return (sz - off < w) ? sz - off : w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] v, chunk;
        int sz, off, lim;
        reg_info(a, v, sz);
        off = part_off(a);
        lim = part_len(off, sz);
        chunk = v >> (8 * off);
        if (lim < 4) chunk = chunk & ((32'd1 << (8 * lim)) - 32'd1);
        return m_big ? bswap(chunk) : chunk;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] v, chunk;
        int sz, off, lim, k;
        reg_info(a, v, sz);
        off = part_off(a);
        lim = part_len(off, sz);
        chunk = m_big ? bswap(wd) : wd;
        for (int j = 0; j < lim; j++) begin
            k = off + j;
            case (int'(a) / 4)
                0: if (k == 0) m_code = chunk[8*j +: 2];
                2: m_mask[8*k +: 8] = chunk[8*j +: 8];
                3: m_scr[8*k +: 8]  = chunk[8*j +: 8];
                default: ;
            endcase
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full access: drive, wait for acknowledge, capture, release.
    task automatic access(input bit is_rd, input logic [7:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        host_addr  = a;
        host_wdata = wd;
        host_sel_n = 1'b0;
        if (is_rd) host_rd_n = 1'b0;
        else       host_wr_n = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (host_ack) begin n = i; break; end
        end
        chk(n == 3, $sformatf("R8 ack latency addr %h", a), n, 3);
        chk(host_rdata_en == is_rd, "R8 read enable with ack", {31'd0, host_rdata_en}, {31'd0, is_rd});
        rd = host_rdata;
        host_sel_n = 1'b1;
        host_rd_n  = 1'b1;
        host_wr_n  = 1'b1;
        @(negedge clk);
        chk(!host_ack, "R8 ack falls after release", {31'd0, host_ack}, 32'd0);
    endtask

    task automatic do_reset(input bit big, input logic [31:0] st);
        rst_n            = 1'b0;
        big_endian_strap = big;
        status_in        = st;
        m_big = big; m_code = 2'd0; m_mask = 32'd0; m_scr = 16'd0; m_stat = st;
        repeat (3) @(negedge clk);
        rst_n            = 1'b1;
        big_endian_strap = ~big;   // R3: later changes must be ignored
        @(negedge clk);
        chk(!host_ack && !host_ack_en && !host_rdata_en, "R10 idle after reset",
            {29'd0, host_ack, host_ack_en, host_rdata_en}, 32'd0);
        chk(irq_n == 1'b1, "R10 irq high with zero mask", {31'd0, irq_n}, 32'd1);
    endtask

    function automatic string tag_for(input logic [7:0] a);
        logic [31:0] v;
        int sz;
        string e, k;
        reg_info(a, v, sz);
        e = m_big ? "R2" : "R1";
        if (sz == 0)              k = "R11";
        else if (sz < port_w())   k = "R6";
        else if (port_w() == 1)   k = "R4";
        else                      k = "R5";
        return {e, "/R3/", k};
    endfunction

    task automatic sweep(input bit big);
        logic [31:0] rd, pat, code_bus;
        for (int w = 0; w < 3; w++) begin
            code_bus = big ? (32'(w) << 24) : 32'(w);
            access(1'b0, 8'h00, code_bus, rd);
            model_write(8'h00, code_bus);
            for (int a = 4; a < 20; a += port_w()) begin
                pat = (32'h9E37_79B9 * 32'(a + 1)) ^ (32'(w) << 28) ^ 32'(big);
                access(1'b0, 8'(a), pat, rd);
                model_write(8'(a), pat);
            end
            for (int a = 0; a < 20; a += port_w()) begin
                access(1'b1, 8'(a), 32'd0, rd);
                chk(rd === exp_read(8'(a)), $sformatf("%s read addr %h width %0d",
                    tag_for(8'(a)), a, 8 * port_w()), rd, exp_read(8'(a)));
            end
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        host_sel_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_addr = 8'h00; host_wdata = 32'd0;
        chip_id = 4'h9; chip_addr = 4'h9;

        // Little-endian phase
        do_reset(1'b0, 32'hFFFF_FFFF);
        access(1'b1, 8'h08, 32'd0, rd);
        chk(rd === 32'd0, "R10 mask byte 0 after reset", rd, 32'd0);
        status_in = 32'hC3A5_0F69; m_stat = 32'hC3A5_0F69;
        sweep(1'b0);

        // Now 32-bit little endian; clear mask
        access(1'b0, 8'h08, 32'd0, rd);
        model_write(8'h08, 32'd0);

        // R7: device address mismatch
        chip_addr = 4'h3;
        @(negedge clk);
        host_addr = 8'h08; host_wdata = 32'hFFFF_FFFF; host_sel_n = 1'b0; host_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(!host_ack && !host_ack_en, "R7 no ack on id mismatch",
            {30'd0, host_ack, host_ack_en}, 32'd0);
        host_sel_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!host_ack && !host_ack_en, "R7 no ack with select high",
            {30'd0, host_ack, host_ack_en}, 32'd0);
        chip_addr = 4'h9;
        host_wr_n = 1'b1;
        access(1'b1, 8'h08, 32'd0, rd);
        chk(rd === m_mask, "R7 mask untouched by unqualified writes", rd, m_mask);

        // R12: abort before acknowledge
        @(negedge clk);
        host_addr = 8'h08; host_wdata = 32'hFFFF_FFFF; host_sel_n = 1'b0; host_wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!host_ack, "R12 no ack before abort", {31'd0, host_ack}, 32'd0);
        host_sel_n = 1'b1; host_wr_n = 1'b1;
        @(negedge clk);
        access(1'b1, 8'h08, 32'd0, rd);
        chk(rd === m_mask, "R12 aborted write ignored", rd, m_mask);

        // R9: interrupt from status and mask
        status_in = 32'd0;
        access(1'b0, 8'h08, 32'h0000_0020, rd);
        model_write(8'h08, 32'h0000_0020);
        chk(irq_n == 1'b1, "R9 irq high, no status", {31'd0, irq_n}, 32'd1);
        @(negedge clk); status_in = 32'h0000_0020;
        @(negedge clk);
        chk(irq_n == 1'b0, "R9 irq low on masked status bit", {31'd0, irq_n}, 32'd0);
        status_in = 32'hFFFF_FFDF;
        @(negedge clk);
        chk(irq_n == 1'b1, "R9 irq high when only unmasked bits set", {31'd0, irq_n}, 32'd1);
        access(1'b0, 8'h08, 32'h8000_0000, rd);
        chk(irq_n == 1'b0, "R9 irq low after mask bit 31 set", {31'd0, irq_n}, 32'd0);

        // Big-endian phase
        do_reset(1'b1, 32'hFFFF_FFFF);
        access(1'b1, 8'h0B, 32'd0, rd);
        chk(rd === 32'd0, "R10 mask byte 3 after reset", rd, 32'd0);
        status_in = 32'h5A3C_E187; m_stat = 32'h5A3C_E187;
        sweep(1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule